// File: doc/BRIEF.md
# Precision DAC Serial Register Interface

This block is the device-side serial port of a single-channel precision voltage DAC. A host sends fixed 24-bit frames over a mode-0 SPI link. Each frame carries a direction flag, a register selector and a 20-bit payload. The block decodes these frames into a small register set: the DAC code, a control word, a clear code and a self-clearing action register. Its outputs go straight to the analog core: the DAC code, the reference-gain select, the ground clamp, the output tristate, the coding select and the linearity-compensation code.

The SPI pins are oversampled on the system clock through synchronisers. A frame is acted on only when chip select returns high and exactly 24 clocks were counted. Readback is one frame late. A read frame names a register. During the next frame, which is normally a no-op, the block shifts out a reply made of a set top bit, the 3-bit address and the register contents. Writes to the action register produce one-cycle strobes for load, clear and soft reset. The code width can be set to 20, 18 or 16 bits. Narrower codes sit left-justified in the 20-bit field.

Top module: `dacif_spi_regs`

## Requirements
- R1: A frame is 24 bits, sent MSB first. Bit 23 set means read and clear means write. Bits 22:20 are the address and bits 19:0 are the payload. A write to address 1 makes `dac_code` equal to payload bits 19 down to 20-CODE_BITS.
- R2: A write to address 2 stores payload bits 9:1 as the control word. Bit 1 is `ref_gain_sel`, bit 2 is `clamp_gnd`, bit 3 is `out_tristate`, bit 4 is `twos_comp`, bit 5 is the serial-output disable and bits 9:6 are `lin_comp`. Payload bits 0 and 19:10 are dropped.
- R3: After reset the control word is 0x00C, so the clamp and the tristate are both on. The code and clear-code registers are zero and every strobe is low.
- R4: A 24-bit read frame to address A makes the next frame shift out {1, A, value} on `miso`, MSB first. The value is the code (address 1), the control word with bit 0 zero (address 2), the clear code (address 3), and zero for addresses 0 and 4 to 7.
- R5: After any frame that is not a valid read, the next frame shifts out all zeros.
- R6: `miso_oe` is high only while `cs_n` is low and the serial-output disable bit is clear.
- R7: A write to address 4 with bit 0 set gives `load_stb` for exactly one cycle and changes no register.
- R8: A write to address 4 with bit 1 set copies the clear code into the DAC code and gives `clear_stb` for one cycle.
- R9: A write to address 4 with bit 2 set puts every register back to its reset value and gives `soft_rst_stb` for one cycle. It then produces neither a load strobe nor a clear strobe.
- R10: A frame whose clock count is not 24 changes no register and produces no strobe.
- R11: Writes to addresses 0, 5, 6 and 7 change nothing.
- R12: With CODE_BITS below 20, the code and clear code keep only the top CODE_BITS payload bits. Their readback shows the dropped low bits as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock, idle low |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial readback data |
| miso_oe | output | 1 | Output enable for miso |
| dac_code | output | CODE_BITS | Code to the converter core |
| ref_gain_sel | output | 1 | Reference buffer gain select |
| clamp_gnd | output | 1 | Clamp output to ground through a resistor |
| out_tristate | output | 1 | Place the output in high impedance |
| twos_comp | output | 1 | Two's-complement coding select |
| lin_comp | output | 4 | Linearity-compensation code |
| load_stb | output | 1 | One-cycle load strobe |
| clear_stb | output | 1 | One-cycle clear strobe |
| soft_rst_stb | output | 1 | One-cycle soft-reset strobe |

## Verification
The assertions assume that the serial inputs are slow compared with the system clock. Each sclk level must last several system cycles, so that every edge passes the synchronisers and is seen exactly once. They also assume that chip select stays high long enough between frames for the commit to land before the next frame starts. The stimulus holds each sclk phase for six system cycles and keeps chip select high for ten cycles between frames. The register-commit and strobe properties therefore always see one commit per frame.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
   localparam int FRAME_BITS = 24;
   localparam int DATA_BITS  = 20;

   localparam logic [2:0] ADR_NOP  = 3'd0;
   localparam logic [2:0] ADR_CODE = 3'd1;
   localparam logic [2:0] ADR_CTRL = 3'd2;
   localparam logic [2:0] ADR_CLR  = 3'd3;
   localparam logic [2:0] ADR_ACT  = 3'd4;

   localparam int CB_REFGAIN = 1;
   localparam int CB_CLAMP   = 2;
   localparam int CB_TRI     = 3;
   localparam int CB_TWOS    = 4;
   localparam int CB_SDOOFF  = 5;
   localparam int CB_LIN_LO  = 6;
   localparam int CB_LIN_HI  = 9;

   localparam int AB_LOAD  = 0;
   localparam int AB_CLEAR = 1;
   localparam int AB_RESET = 2;

   localparam logic [9:0] CTRL_RST = 10'h00C;

   typedef struct packed {
      logic                 rd;
      logic [2:0]           addr;
      logic [DATA_BITS-1:0] data;
   } frame_t;
endpackage

// File: rtl/dacif_sync_edge.sv
module dacif_sync_edge #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic level,
   output logic rise,
   output logic fall
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dacif_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;
   logic              prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= {STAGES{RST_VAL}};
         prev  <= RST_VAL;
      end else begin
         chain <= {chain[STAGES-2:0], async_in};
         prev  <= chain[STAGES-1];
      end
   end

   assign level = chain[STAGES-1];
   assign rise  = level & ~prev;
   assign fall  = ~level & prev;
endmodule

// File: rtl/dacif_shifter.sv
module dacif_shifter #(
   parameter int FRAME_BITS = 24
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sclk_rise,
   input  logic                  sclk_fall,
   input  logic                  cs_lvl,
   input  logic                  cs_fall,
   input  logic                  cs_rise,
   input  logic                  mosi_lvl,
   input  logic [FRAME_BITS-1:0] tx_word,
   output logic [FRAME_BITS-1:0] rx_word,
   output logic                  frame_ok,
   output logic                  miso_bit
);
   localparam int CW = $clog2(FRAME_BITS + 2);
   localparam logic [CW-1:0] FULL = FRAME_BITS[CW-1:0];

   logic [CW-1:0]         bit_cnt;
   logic [FRAME_BITS-1:0] tx_sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         rx_word <= '0;
      end else if (cs_fall) begin
         bit_cnt <= '0;
      end else if (sclk_rise && !cs_lvl) begin
         rx_word <= {rx_word[FRAME_BITS-2:0], mosi_lvl};
         if (bit_cnt != '1) bit_cnt <= bit_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tx_sr <= '0;
      else if (cs_rise) tx_sr <= tx_word;
      else if (sclk_fall && !cs_lvl) tx_sr <= {tx_sr[FRAME_BITS-2:0], 1'b0};
   end

   assign frame_ok = cs_rise && (bit_cnt == FULL);
   assign miso_bit = tx_sr[FRAME_BITS-1];
endmodule

// File: rtl/dacif_regs.sv
module dacif_regs
   import dacif_pkg::*;
#(
   parameter int CODE_BITS = 20
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 frame_ok,
   input  frame_t               frm,
   output logic [CODE_BITS-1:0] code_q,
   output logic [CODE_BITS-1:0] clr_q,
   output logic [9:1]           ctrl_q,
   output logic [DATA_BITS-1:0] rd_data,
   output logic                 load_stb,
   output logic                 clear_stb,
   output logic                 soft_rst_stb
);
   localparam int SHIFT = DATA_BITS - CODE_BITS;

   logic [DATA_BITS-1:0] code_full;
   logic [DATA_BITS-1:0] clr_full;

   generate
      if (SHIFT == 0) begin : g_full
         assign code_full = code_q;
         assign clr_full  = clr_q;
      end else begin : g_ljust
         assign code_full = {code_q, {SHIFT{1'b0}}};
         assign clr_full  = {clr_q, {SHIFT{1'b0}}};
      end
   endgenerate

   always_comb begin
      case (frm.addr)
         ADR_CODE: rd_data = code_full;
         ADR_CTRL: rd_data = {{(DATA_BITS-10){1'b0}}, ctrl_q, 1'b0};
         ADR_CLR:  rd_data = clr_full;
         default:  rd_data = '0;
      endcase
   end

   logic wr_go;
   assign wr_go = frame_ok && !frm.rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q       <= '0;
         clr_q        <= '0;
         ctrl_q       <= CTRL_RST[9:1];
         load_stb     <= 1'b0;
         clear_stb    <= 1'b0;
         soft_rst_stb <= 1'b0;
      end else begin
         load_stb     <= 1'b0;
         clear_stb    <= 1'b0;
         soft_rst_stb <= 1'b0;
         if (wr_go) begin
            case (frm.addr)
               ADR_CODE: code_q <= frm.data[DATA_BITS-1 -: CODE_BITS];
               ADR_CTRL: ctrl_q <= frm.data[9:1];
               ADR_CLR:  clr_q  <= frm.data[DATA_BITS-1 -: CODE_BITS];
               ADR_ACT: begin
                  if (frm.data[AB_RESET]) begin
                     code_q       <= '0;
                     clr_q        <= '0;
                     ctrl_q       <= CTRL_RST[9:1];
                     soft_rst_stb <= 1'b1;
                  end else begin
                     if (frm.data[AB_CLEAR]) begin
                        code_q    <= clr_q;
                        clear_stb <= 1'b1;
                     end
                     if (frm.data[AB_LOAD]) load_stb <= 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/dacif_spi_regs.sv
module dacif_spi_regs
   import dacif_pkg::*;
#(
   parameter int CODE_BITS   = 20,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sclk,
   input  logic                 cs_n,
   input  logic                 mosi,
   output logic                 miso,
   output logic                 miso_oe,
   output logic [CODE_BITS-1:0] dac_code,
   output logic                 ref_gain_sel,
   output logic                 clamp_gnd,
   output logic                 out_tristate,
   output logic                 twos_comp,
   output logic [3:0]           lin_comp,
   output logic                 load_stb,
   output logic                 clear_stb,
   output logic                 soft_rst_stb
);
   generate
      if (CODE_BITS != 20 && CODE_BITS != 18 && CODE_BITS != 16) begin : g_bad_width
         $error("dacif_spi_regs: CODE_BITS must be 16, 18 or 20");
      end
   endgenerate

   logic sclk_lvl, sclk_rise, sclk_fall;
   logic cs_lvl, cs_rise, cs_fall;
   logic mosi_lvl, mosi_rise_nc, mosi_fall_nc;

   dacif_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
      .clk(clk), .rst_n(rst_n), .async_in(sclk),
      .level(sclk_lvl), .rise(sclk_rise), .fall(sclk_fall));
   dacif_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
      .clk(clk), .rst_n(rst_n), .async_in(cs_n),
      .level(cs_lvl), .rise(cs_rise), .fall(cs_fall));
   dacif_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
      .clk(clk), .rst_n(rst_n), .async_in(mosi),
      .level(mosi_lvl), .rise(mosi_rise_nc), .fall(mosi_fall_nc));

   logic [FRAME_BITS-1:0] rx_word, tx_word;
   logic                  frame_ok;
   frame_t                frm;
   logic [DATA_BITS-1:0]  rd_data;
   logic [9:1]            ctrl_q;
   logic [CODE_BITS-1:0]  clr_code;
   logic                  sdo_off;

   assign frm     = frame_t'(rx_word);
   assign tx_word = (frame_ok && frm.rd) ? {1'b1, frm.addr, rd_data} : '0;

   dacif_shifter #(.FRAME_BITS(FRAME_BITS)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
      .cs_lvl(cs_lvl), .cs_fall(cs_fall), .cs_rise(cs_rise),
      .mosi_lvl(mosi_lvl), .tx_word(tx_word),
      .rx_word(rx_word), .frame_ok(frame_ok), .miso_bit(miso));

   dacif_regs #(.CODE_BITS(CODE_BITS)) u_regs (
      .clk(clk), .rst_n(rst_n), .frame_ok(frame_ok), .frm(frm),
      .code_q(dac_code), .clr_q(clr_code), .ctrl_q(ctrl_q),
      .rd_data(rd_data), .load_stb(load_stb), .clear_stb(clear_stb),
      .soft_rst_stb(soft_rst_stb));

   assign ref_gain_sel = ctrl_q[CB_REFGAIN];
   assign clamp_gnd    = ctrl_q[CB_CLAMP];
   assign out_tristate = ctrl_q[CB_TRI];
   assign twos_comp    = ctrl_q[CB_TWOS];
   assign sdo_off      = ctrl_q[CB_SDOOFF];
   assign lin_comp     = ctrl_q[CB_LIN_HI:CB_LIN_LO];
   assign miso_oe      = ~cs_n & ~sdo_off;
endmodule

// File: rtl/dacif_spi_regs_chk.sv
module dacif_spi_regs_chk #(
   parameter int CODE_BITS = 20
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cs_n,
   input logic                 miso_oe,
   input logic                 sdo_off,
   input logic                 frame_ok,
   input logic [CODE_BITS-1:0] dac_code,
   input logic [CODE_BITS-1:0] clr_code,
   input logic                 clamp_gnd,
   input logic                 out_tristate,
   input logic                 load_stb,
   input logic                 clear_stb,
   input logic                 soft_rst_stb
);
   // R7
   load_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_stb |=> !load_stb);

   // R8
   clear_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear_stb |-> dac_code == $past(clr_code));

   // R9
   rst_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_stb |-> (!load_stb && !clear_stb));

   // R9
   rst_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_stb |-> (clamp_gnd && out_tristate && dac_code == '0));

   // R6
   oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !miso_oe);

   // R6
   oe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sdo_off |-> !miso_oe);

   // R10
   code_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dac_code) |-> $past(frame_ok));
endmodule

bind dacif_spi_regs dacif_spi_regs_chk #(.CODE_BITS(CODE_BITS)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .miso_oe(miso_oe),
   .sdo_off(sdo_off), .frame_ok(frame_ok), .dac_code(dac_code),
   .clr_code(clr_code), .clamp_gnd(clamp_gnd), .out_tristate(out_tristate),
   .load_stb(load_stb), .clear_stb(clear_stb), .soft_rst_stb(soft_rst_stb));

// File: tb/sim_dacif_spi_regs.sv
`timescale 1ns/1ps
module sim_dacif_spi_regs;
   localparam int H = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
   always #2.5 clk = ~clk;

   logic        miso, miso_oe, rg, cg, tr, tc, ls, cs_s, rs;
   logic [19:0] code0;
   logic [3:0]  lin;
   logic        miso1, oe1, rg1, cg1, tr1, tc1, ls1, cl1, rs1;
   logic [15:0] code1;
   logic [3:0]  lin1;

   dacif_spi_regs u0 (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
      .miso(miso), .miso_oe(miso_oe), .dac_code(code0), .ref_gain_sel(rg),
      .clamp_gnd(cg), .out_tristate(tr), .twos_comp(tc), .lin_comp(lin),
      .load_stb(ls), .clear_stb(cs_s), .soft_rst_stb(rs));

   dacif_spi_regs #(.CODE_BITS(16)) u1 (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
      .miso(miso1), .miso_oe(oe1), .dac_code(code1), .ref_gain_sel(rg1),
      .clamp_gnd(cg1), .out_tristate(tr1), .twos_comp(tc1), .lin_comp(lin1),
      .load_stb(ls1), .clear_stb(cl1), .soft_rst_stb(rs1));

   int n_chk = 0, n_fail = 0;
   int cyc = 0;
   bit settled = 1'b0;
   bit done = 1'b0;

   // reference model state
   logic [19:0] m_code = '0, m_clr = '0;
   logic [9:0]  m_ctrl = 10'h00C;
   logic [23:0] exp0 = '0, exp1 = '0;
   bit          prev_rd = 1'b0;
   int e_load = 0, e_clr = 0, e_rst = 0;
   int n_load = 0, n_clr = 0, n_rst = 0, n_long = 0;
   logic ls_d = 1'b0, cl_d = 1'b0, rs_d = 1'b0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [19:0] rv(input logic [2:0] a, input bit narrow);
      logic [19:0] msk;
      msk = narrow ? 20'hFFFF0 : 20'hFFFFF;
      case (a)
         3'd1: return m_code & msk;
         3'd2: return {10'd0, m_ctrl};
         3'd3: return m_clr & msk;
         default: return 20'd0;
      endcase
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   // strobe monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (ls) n_load++;
         if (cs_s) n_clr++;
         if (rs) n_rst++;
         if ((ls && ls_d) || (cs_s && cl_d) || (rs && rs_d)) n_long++;
      end
      ls_d <= ls; cl_d <= cs_s; rs_d <= rs;
   end

   // per-clock comparison with the model while quiet
   always @(negedge clk) begin
      if (settled) begin
         chk("R1 code", 32'(code0), 32'(m_code));
         chk("R12 narrow code", 32'(code1), 32'(m_code[19:4]));
         chk("R2 ctrl", {26'd0, lin, tc, tr, cg, rg},
             {26'd0, m_ctrl[9:6], m_ctrl[4], m_ctrl[3], m_ctrl[2], m_ctrl[1]});
      end
   end

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog act=%0d exp=<150000", cyc);
         finish_run();
      end
   end

   task automatic xfer(input logic [23:0] w, input int nbits);
      logic [23:0] got0, got1;
      int oe_hi;
      bit sdo_dis;
      int l0, c0, r0;
      got0 = '0; got1 = '0; oe_hi = 0;
      sdo_dis = m_ctrl[5];
      l0 = n_load; c0 = n_clr; r0 = n_rst;
      settled = 1'b0;
      cs_n = 1'b0;
      repeat (H) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         mosi = (i < 24) ? w[23-i] : 1'b0;
         repeat (H) @(negedge clk);
         if (i < 24) begin
            got0[23-i] = miso;
            got1[23-i] = miso1;
         end
         if (miso_oe) oe_hi++;
         sclk = 1'b1;
         repeat (H) @(negedge clk);
         sclk = 1'b0;
      end
      repeat (H) @(negedge clk);
      cs_n = 1'b1;
      repeat (10) @(negedge clk);
      // readback of the previous frame's request
      if (nbits == 24) begin
         chk(prev_rd ? "R4 readback" : "R5 empty reply", 32'(got0), 32'(exp0));
         chk(prev_rd ? "R12 narrow readback" : "R5 narrow empty", 32'(got1), 32'(exp1));
      end
      chk("R6 oe count", oe_hi, sdo_dis ? 0 : nbits);
      // model update
      exp0 = '0; exp1 = '0; prev_rd = 1'b0;
      e_load = 0; e_clr = 0; e_rst = 0;
      if (nbits == 24) begin
         if (w[23]) begin
            prev_rd = 1'b1;
            exp0 = {1'b1, w[22:20], rv(w[22:20], 1'b0)};
            exp1 = {1'b1, w[22:20], rv(w[22:20], 1'b1)};
         end else begin
            case (w[22:20])
               3'd1: m_code = w[19:0];
               3'd2: m_ctrl = w[9:0] & 10'h3FE;
               3'd3: m_clr = w[19:0];
               3'd4: begin
                  if (w[2]) begin
                     m_code = '0; m_clr = '0; m_ctrl = 10'h00C; e_rst = 1;
                  end else begin
                     if (w[1]) begin m_code = m_clr; e_clr = 1; end
                     if (w[0]) e_load = 1;
                  end
               end
               default: ;
            endcase
         end
      end
      chk("R7 load strobes", n_load - l0, e_load);
      chk("R8 clear strobes", n_clr - c0, e_clr);
      chk("R9 reset strobes", n_rst - r0, e_rst);
      settled = 1'b1;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      // R3 reset state
      chk("R3 clamp", 32'(cg), 32'd1);
      chk("R3 tristate", 32'(tr), 32'd1);
      chk("R3 code", 32'(code0), 32'd0);
      chk("R3 strobes", {29'd0, ls, cs_s, rs}, 32'd0);
      chk("R6 idle oe", 32'(miso_oe), 32'd0);
      settled = 1'b1;
      repeat (20) @(negedge clk);

      xfer({1'b1, 3'd2, 20'd0}, 24);        // R3/R4 read control at reset
      xfer(24'h000000, 24);
      xfer({1'b0, 3'd1, 20'hABCDE}, 24);    // R1 write code
      xfer({1'b1, 3'd1, 20'd0}, 24);        // R4/R12 read code
      xfer(24'h000000, 24);
      xfer({1'b0, 3'd2, 20'hFFF12}, 24);    // R2 control with junk bits
      xfer({1'b1, 3'd2, 20'd0}, 24);
      xfer({1'b0, 3'd3, 20'h12345}, 24);    // R5 reply after write is zero
      xfer({1'b1, 3'd3, 20'd0}, 24);        // R4 clear code
      xfer({1'b0, 3'd4, 20'h00001}, 24);    // R7 load
      chk("R7 code unchanged", 32'(code0), 32'hABCDE);
      xfer({1'b0, 3'd4, 20'h00002}, 24);    // R8 clear
      chk("R8 code from clear", 32'(code0), 32'h12345);
      xfer({1'b0, 3'd5, 20'hFFFFF}, 24);    // R11 ignored addresses
      xfer({1'b0, 3'd0, 20'hFFFFF}, 24);
      xfer({1'b0, 3'd7, 20'h00007}, 24);
      chk("R11 code kept", 32'(code0), 32'h12345);
      xfer({1'b1, 3'd4, 20'd0}, 24);        // R4 action reg reads zero
      xfer({1'b1, 3'd6, 20'd0}, 24);
      xfer({1'b0, 3'd1, 20'h11111}, 23);    // R10 short frame
      xfer({1'b0, 3'd1, 20'h22222}, 25);    // R10 long frame
      chk("R10 code kept", 32'(code0), 32'h12345);
      xfer({1'b1, 3'd1, 20'd0}, 23);        // short read gives no reply
      xfer(24'h000000, 24);
      xfer({1'b0, 3'd4, 20'h00003}, 24);    // R7+R8 together
      xfer({1'b0, 3'd2, 20'h00020}, 24);    // R6 disable serial output
      xfer({1'b1, 3'd2, 20'd0}, 24);
      xfer({1'b0, 3'd2, 20'h00310}, 24);    // R6 re-enable, lin 12
      xfer({1'b0, 3'd1, 20'h0F0F7}, 24);
      xfer({1'b0, 3'd4, 20'h00007}, 24);    // R9 reset wins over load/clear
      chk("R9 clamp back", 32'(cg), 32'd1);
      xfer({1'b1, 3'd2, 20'd0}, 24);
      xfer({1'b1, 3'd1, 20'd0}, 24);
      xfer(24'h000000, 24);
      chk("R7 single-cycle strobes", n_long, 0);
      finish_run();
   end
endmodule